// File: doc/BRIEF.md
# Two-Operand ALU with Opcode Decode

This block is the execute stage for the two-operand instruction group of a 16-bit processor. It takes an instruction word, with the source and destination operand values already fetched, and decodes the top four bits of the word. One clock later it presents the value to write back, a write-back enable, a byte-lane mask and the four condition flags N, Z, V and C. It also presents the two six-bit operand specifiers, so that the write-back stage can find where the result goes.

The byte forms work only on the low eight bits. The upper byte of the result is the destination's upper byte, passed through unchanged. The two test forms (compare and bit test) set the flags but never request a write. Compare subtracts the destination from the source. Top-nibble values that belong to other instruction groups are refused with a not-mine pulse. A refused word leaves the result and the flags as they were.

Top module: `two_op_alu`

## Requirements
- R1: Top-nibble values 0x0, 0x7, 0x8 and 0xF are not handled. One cycle after such a word is offered, not_mine is 1, res_valid is 0 and res_wb is 0. The result, the flags, the lanes and the specifiers keep their previous values.
- R2: Arithmetic operations. Opcode 0x1 gives dst+src, with C as the carry out of bit 15. Opcode 0x2 gives dst−src, with C as the borrow (dst < src unsigned). For both, V is the two's-complement overflow of the 16-bit operation.
- R3: Logical operations. Opcode 0x3 gives dst AND src, 0x4 gives dst AND NOT src, 0x5 gives dst OR src and 0x6 gives dst XOR src. For all four, res_wb is 1 and V and C are 0.
- R4: Test operations never write. Opcode 0x9 computes src−dst, with C as the borrow (src < dst) and V as the signed overflow. Opcode 0xA computes dst AND src with V=C=0. For both, res_wb is 0 while res_valid is 1, and res_data shows the computed value.
- R5: Opcode 0xB copies src to the result, with res_wb=1 and V=C=0.
- R6: Byte operations are 0xC (src−dst on the low bytes, with C as the 8-bit borrow and V as the 8-bit overflow; no write), 0xD (move the low byte) and 0xE (OR the low bytes, V=C=0). For all three, res_data[15:8] equals dst[15:8] and res_lanes is 2'b01. Word operations give res_lanes 2'b11.
- R7: N is bit 7 of the result for byte operations and bit 15 for word operations. Z is 1 when the low 8 bits (byte) or all 16 bits (word) of the result are zero.
- R8: Results appear on the clock edge after the offer. With op_valid low, the next cycle has res_valid, res_wb and not_mine at 0, and res_data and the flags hold.
- R9: src_sel is bits 11:6 and dst_sel is bits 5:0 of the last accepted instruction.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction and operands offered this cycle |
| instr | input | 16 | Instruction word |
| src_val | input | 16 | Source operand value |
| dst_val | input | 16 | Destination operand value |
| res_valid | output | 1 | A handled instruction completed |
| res_data | output | 16 | Result value |
| res_wb | output | 1 | Result must be written back |
| res_lanes | output | 2 | Byte lanes to write (bit 0 low byte) |
| not_mine | output | 1 | Offered word belongs to another group |
| src_sel | output | 6 | Source specifier of the accepted word |
| dst_sel | output | 6 | Destination specifier of the accepted word |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry or borrow |

## Verification
Directed operand pairs are placed at the edges of the arithmetic: 0x7FFF+1 and 0x8000−1 for signed overflow, 0xFFFF+1 for carry with a zero result, and 0−1 for borrow. These separate the carry from the overflow, and the dst−src order from the src−dst order. Equal operands in compare and disjoint masks in bit test expose the Z flag and the missing write. Byte cases use upper bytes that differ from the source, so a lane leak or a flag taken from bit 15 shows up. A long run of random words over all sixteen nibbles, mixed with idle cycles, tests decode and the holding behaviour against the model.

// File: rtl/two_op_alu.sv
module two_op_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [15:0] instr,
  input  logic [15:0] src_val,
  input  logic [15:0] dst_val,
  output logic        res_valid,
  output logic [15:0] res_data,
  output logic        res_wb,
  output logic [1:0]  res_lanes,
  output logic        not_mine,
  output logic [5:0]  src_sel,
  output logic [5:0]  dst_sel,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);

  logic [3:0]  op;
  logic        known, is_byte, wb, v, c;
  logic [15:0] r;
  logic [16:0] add17, dms17, smd17;
  logic [8:0]  smd9;
  logic [7:0]  lo;

  assign op    = instr[15:12];
  assign add17 = {1'b0, dst_val} + {1'b0, src_val};
  assign dms17 = {1'b0, dst_val} - {1'b0, src_val};
  assign smd17 = {1'b0, src_val} - {1'b0, dst_val};
  assign smd9  = {1'b0, src_val[7:0]} - {1'b0, dst_val[7:0]};

  always_comb begin
    known   = 1'b1;
    is_byte = 1'b0;
    wb      = 1'b1;
    v       = 1'b0;
    c       = 1'b0;
    r       = 16'h0000;
    lo      = 8'h00;
    case (op)
      4'h1: begin
        r = add17[15:0];
        c = add17[16];
        v = (dst_val[15] == src_val[15]) && (r[15] != dst_val[15]);
      end
      4'h2: begin
        r = dms17[15:0];
        c = dms17[16];
        v = (dst_val[15] != src_val[15]) && (r[15] != dst_val[15]);
      end
      4'h3: r = dst_val & src_val;
      4'h4: r = dst_val & ~src_val;
      4'h5: r = dst_val | src_val;
      4'h6: r = dst_val ^ src_val;
      4'h9: begin
        r  = smd17[15:0];
        c  = smd17[16];
        v  = (src_val[15] != dst_val[15]) && (r[15] != src_val[15]);
        wb = 1'b0;
      end
      4'hA: begin
        r  = dst_val & src_val;
        wb = 1'b0;
      end
      4'hB: r = src_val;
      4'hC: begin
        is_byte = 1'b1;
        lo      = smd9[7:0];
        c       = smd9[8];
        v       = (src_val[7] != dst_val[7]) && (lo[7] != src_val[7]);
        wb      = 1'b0;
      end
      4'hD: begin
        is_byte = 1'b1;
        lo      = src_val[7:0];
      end
      4'hE: begin
        is_byte = 1'b1;
        lo      = dst_val[7:0] | src_val[7:0];
      end
      default: begin
        known = 1'b0;
        wb    = 1'b0;
      end
    endcase
    if (is_byte) r = {dst_val[15:8], lo};
  end

  logic take;
  assign take = op_valid && known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_wb    <= 1'b0;
      not_mine  <= 1'b0;
      res_data  <= 16'h0000;
      res_lanes <= 2'b00;
      src_sel   <= 6'd0;
      dst_sel   <= 6'd0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      res_valid <= take;
      res_wb    <= take && wb;
      not_mine  <= op_valid && !known;
      if (take) begin
        res_data  <= r;
        res_lanes <= is_byte ? 2'b01 : 2'b11;
        src_sel   <= instr[11:6];
        dst_sel   <= instr[5:0];
        flag_n    <= is_byte ? r[7] : r[15];
        flag_z    <= is_byte ? (r[7:0] == 8'h00) : (r == 16'h0000);
        flag_v    <= v;
        flag_c    <= c;
      end
    end
  end

endmodule

// File: rtl/two_op_alu_checks.sv
module two_op_alu_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [15:0] instr,
  input logic [15:0] dst_val,
  input logic        res_valid,
  input logic [15:0] res_data,
  input logic        res_wb,
  input logic [1:0]  res_lanes,
  input logic        not_mine,
  input logic        flag_z,
  input logic        flag_v,
  input logic        flag_c
);
  logic [3:0] op;
  assign op = instr[15:12];

  a_r1_foreign_decode: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 4'h0 || op == 4'h7 || op == 4'h8 || op == 4'hF) |=> not_mine);

  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    not_mine |-> !res_valid && !res_wb);

  a_r3_logic_no_vc: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op >= 4'h3 && op <= 4'h6) |=> res_wb && !flag_v && !flag_c);

  a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 4'h9 || op == 4'hA || op == 4'hC) |=> res_valid && !res_wb);

  a_r6_byte_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op >= 4'hC && op <= 4'hE) |=>
      res_lanes == 2'b01 && res_data[15:8] == $past(dst_val[15:8]));

  a_r7_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_lanes == 2'b11 |-> flag_z == (res_data == 16'h0000));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid && !res_wb && !not_mine && $stable(res_data));
endmodule

bind two_op_alu two_op_alu_checks u_checks (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr), .dst_val(dst_val),
  .res_valid(res_valid), .res_data(res_data), .res_wb(res_wb), .res_lanes(res_lanes),
  .not_mine(not_mine), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/test_two_op_alu.sv
module test_two_op_alu;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [15:0] instr = '0, src_val = '0, dst_val = '0;
  logic res_valid, res_wb, not_mine, flag_n, flag_z, flag_v, flag_c;
  logic [15:0] res_data;
  logic [1:0] res_lanes;
  logic [5:0] src_sel, dst_sel;

  two_op_alu i_two_op_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
    .src_val(src_val), .dst_val(dst_val), .res_valid(res_valid),
    .res_data(res_data), .res_wb(res_wb), .res_lanes(res_lanes),
    .not_mine(not_mine), .src_sel(src_sel), .dst_sel(dst_sel),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int e_valid = 0, e_wb = 0, e_nm = 0, e_data = 0, e_lanes = 0;
  int e_ssel = 0, e_dsel = 0, e_n = 0, e_z = 0, e_v = 0, e_c = 0;
  string e_req = "R10";

  task automatic chk(string what, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sx(int x, int bits);
    return (x >= (1 << (bits - 1))) ? x - (1 << bits) : x;
  endfunction

  function automatic int ovf(int val, int bits);
    return (val > (1 << (bits - 1)) - 1 || val < -(1 << (bits - 1))) ? 1 : 0;
  endfunction

  task automatic model(input logic vld, input logic [15:0] ins, s, d);
    int op = int'(ins[15:12]);
    int si = int'(s), di = int'(d), s8 = int'(s[7:0]), d8 = int'(d[7:0]);
    int r = 0, v = 0, c = 0, wb = 1, byt = 0, known = 1;
    string req = "R2";
    e_valid = 0; e_wb = 0; e_nm = 0;
    if (!vld) return;
    case (op)
      1: begin r = (di + si) % 65536; c = (di + si > 65535); v = ovf(sx(di,16) + sx(si,16), 16); end
      2: begin r = (di - si + 65536) % 65536; c = (di < si); v = ovf(sx(di,16) - sx(si,16), 16); end
      3: begin r = di & si; req = "R3"; end
      4: begin r = di & (~si & 65535); req = "R3"; end
      5: begin r = di | si; req = "R3"; end
      6: begin r = di ^ si; req = "R3"; end
      9: begin r = (si - di + 65536) % 65536; c = (si < di); v = ovf(sx(si,16) - sx(di,16), 16); wb = 0; req = "R4"; end
      10: begin r = di & si; wb = 0; req = "R4"; end
      11: begin r = si; req = "R5"; end
      12: begin r = (s8 - d8 + 256) % 256; c = (s8 < d8); v = ovf(sx(s8,8) - sx(d8,8), 8); wb = 0; byt = 1; req = "R6"; end
      13: begin r = s8; byt = 1; req = "R6"; end
      14: begin r = s8 | d8; byt = 1; req = "R6"; end
      default: known = 0;
    endcase
    if (!known) begin e_nm = 1; e_req = "R1"; return; end
    e_req = req;
    e_valid = 1; e_wb = wb;
    if (byt) begin
      e_data = (di & 16'hFF00) | r; e_lanes = 1; e_n = (r >= 128); e_z = (r == 0);
    end else begin
      e_data = r; e_lanes = 3; e_n = (r >= 32768); e_z = (r == 0);
    end
    e_v = v; e_c = c;
    e_ssel = int'(ins[11:6]); e_dsel = int'(ins[5:0]);
  endtask

  task automatic compare_all();
    chk("res_valid", "R8", int'(res_valid), e_valid);
    chk("res_wb", "R8", int'(res_wb), e_wb);
    chk("not_mine", "R1", int'(not_mine), e_nm);
    chk("res_data", e_req, int'(res_data), e_data);
    chk("res_lanes", "R6", int'(res_lanes), e_lanes);
    chk("src_sel", "R9", int'(src_sel), e_ssel);
    chk("dst_sel", "R9", int'(dst_sel), e_dsel);
    chk("flag_n", "R7", int'(flag_n), e_n);
    chk("flag_z", "R7", int'(flag_z), e_z);
    chk("flag_v", e_req, int'(flag_v), e_v);
    chk("flag_c", e_req, int'(flag_c), e_c);
  endtask

  task automatic step(input logic vld, input logic [15:0] ins, s, d);
    @(negedge clk);
    compare_all();
    op_valid = vld; instr = ins; src_val = s; dst_val = d;
    model(vld, ins, s, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all();               // R10 reset state
    rst_n = 1'b1;
    step(1, 16'h1041, 16'h0001, 16'h7FFF);  // R2 ADD signed overflow
    step(1, 16'h1082, 16'h0001, 16'hFFFF);  // R2 ADD carry, zero
    step(1, 16'h2003, 16'h0001, 16'h0000);  // R2 SUB borrow
    step(1, 16'h2FFF, 16'h0001, 16'h8000);  // R2 SUB overflow
    step(1, 16'h3000, 16'h0F0F, 16'h00FF);  // R3
    step(1, 16'h4000, 16'h0F0F, 16'h00FF);  // R3
    step(1, 16'h5000, 16'h0F0F, 16'h00FF);  // R3
    step(1, 16'h6000, 16'h00FF, 16'h00FF);  // R3 zero
    step(1, 16'h9000, 16'h1234, 16'h1234);  // R4 CMP equal
    step(1, 16'h9000, 16'h0001, 16'h0002);  // R4 CMP borrow
    step(1, 16'h9000, 16'h8000, 16'h0001);  // R4 CMP overflow
    step(1, 16'hA000, 16'hF0F0, 16'h0F0F);  // R4 BIT zero
    step(1, 16'hB155, 16'h8000, 16'h1234);  // R5 MOV negative
    step(1, 16'hC000, 16'h0080, 16'hAB01);  // R6 CMPB overflow
    step(1, 16'hC000, 16'h1200, 16'h3401);  // R6 CMPB borrow
    step(1, 16'hD000, 16'hFF80, 16'h5A00);  // R6 MOVB negative
    step(1, 16'hE000, 16'h0000, 16'hFF00);  // R6 R7 BISB zero high set
    step(1, 16'h0123, 16'h1111, 16'h2222);  // R1
    step(1, 16'h7ABC, 16'h1111, 16'h2222);  // R1
    step(1, 16'h8000, 16'h1111, 16'h2222);  // R1
    step(1, 16'hFFFF, 16'h1111, 16'h2222);  // R1
    step(0, 16'h1000, 16'h1111, 16'h2222);  // R8 idle
    step(0, 16'h0000, 16'h0000, 16'h0000);
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, 16'($urandom), 16'($urandom), 16'($urandom));
    step(0, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);
    compare_all();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule